// File: doc/BRIEF.md
# Protection configuration register file

This block stores the software-visible setup of a memory protection unit: one configuration byte and one address register for each of sixteen protection entries. Software reaches the storage through a CSR-style port made of a write enable, a read strobe, a class select (configuration or address), an index and XLEN-wide data. Configuration bytes are grouped into words of XLEN/8 bytes. With XLEN = 64 only even configuration indices exist, and an even index is halved to find the word.

Writes are screened by lock rules. A configuration byte whose lock bit is set no longer accepts writes. An address register is frozen when its own entry is locked. It is also frozen when the next entry is a locked top-of-range entry, because that entry uses this register as its lower bound. Stored address values are cleared below the 4 KiB page granule. The whole entry table is driven out in parallel for the access checker, which lives elsewhere.

Top module: `prot_cfg_regfile`

## Requirements
- R1: After reset every configuration byte and every address register is zero, and lock bits can be cleared only by reset.
- R2: Configuration register n carries the bytes of entries n*(XLEN/8)+i, with byte i at data bits [8i+7:8i] (byte 0 least significant). A write with we_i=1 and sel_addr_i=0 stores them, and a read with re_i=1 and sel_addr_i=0 returns them.
- R3: When XLEN is 64, a configuration write to an odd index changes nothing and a read of an odd index returns zero. An even index is halved before mapping.
- R4: A configuration index whose word lies past the last entry reads as zero and ignores writes.
- R5: Bit 7 of a configuration byte is its lock. A locked byte keeps its value while the unlocked bytes of the same word still update.
- R6: An address write (we_i=1, sel_addr_i=1) to entry e is ignored while entry e is locked.
- R7: An address write to entry e is also ignored when entry e+1 is locked and its mode field, bits [4:3], equals 01 (top of range). A locked entry e+1 in any other mode does not freeze entry e.
- R8: An address index equal to or above the entry count (16) reads as zero and ignores writes.
- R9: A stored address value has its low 10 bits cleared (4 KiB page granule on a word address).
- R10: rdata_o follows the stored state combinationally while re_i=1 and is zero while re_i=0. A write becomes visible after the next rising clock edge, and nothing changes while we_i=0.
- R11: cfg_table_o bits [8e+7:8e] hold the configuration byte of entry e, and addr_table_o bits [XLEN*e+XLEN-1:XLEN*e] hold the address register of entry e.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Write enable |
| re_i | input | 1 | Read strobe |
| sel_addr_i | input | 1 | Class select: 0 configuration, 1 address |
| idx_i | input | IDX_W (5) | Register index |
| wdata_i | input | XLEN | Write data |
| rdata_o | output | XLEN | Read data |
| cfg_table_o | output | 8*N_ENTRIES | All configuration bytes |
| addr_table_o | output | XLEN*N_ENTRIES | All address registers |

## Verification
The hardest case to reach is the frozen address register whose freeze comes from its neighbour. The stimulus must first program entry e+1 as a locked top-of-range entry and then write entry e, and it must do the same with a locked neighbour in another mode to show the contrast. A word that mixes locked and unlocked bytes needs a locking write followed by a full-word overwrite. The bench drives 32-bit and 64-bit instances from the same stimulus, so odd and out-of-range indices land differently in each. A directed prologue sets up these cases, and long random runs with indices biased toward the valid range then pile up locks. A behavioural model of the entry table is compared every cycle.

// File: rtl/prot_cfg_pkg.sv
package prot_cfg_pkg;
  localparam int LOCK_BIT = 7;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_TOR   = 2'b01,
    MODE_NA4   = 2'b10,
    MODE_NAPOT = 2'b11
  } match_mode_e;

  function automatic match_mode_e mode_of(input logic [7:0] cfg);
    return match_mode_e'(cfg[4:3]);
  endfunction
endpackage

// File: rtl/prot_cfg_bank.sv
module prot_cfg_bank
  import prot_cfg_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int N_ENTRIES = 16,
  parameter int IDX_W     = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [XLEN-1:0]            wdata_i,
  output logic [XLEN-1:0]            rdata_o,
  output logic [N_ENTRIES-1:0][7:0]  cfg_q_o,
  output logic [N_ENTRIES-1:0]       addr_lock_o
);
  localparam int  BPW     = XLEN / 8;
  localparam int  N_WORDS = N_ENTRIES / BPW;
  localparam bit  WIDE    = (XLEN == 64);

  logic [N_ENTRIES-1:0][7:0] cfg_q;
  logic [IDX_W-1:0]          word_idx;
  logic                      idx_ok;

  assign word_idx = WIDE ? {1'b0, idx_i[IDX_W-1:1]} : idx_i;
  assign idx_ok   = !(WIDE && idx_i[0]) && (word_idx < IDX_W'(N_WORDS));

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_entry
    localparam int W = e / BPW;
    localparam int B = e % BPW;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cfg_q[e] <= '0;
      else if (we_i && idx_ok && word_idx == IDX_W'(W) && !cfg_q[e][LOCK_BIT])
        cfg_q[e] <= wdata_i[B*8 +: 8];
    end

    // address register frozen by own lock or a locked TOR successor
    if (e < N_ENTRIES - 1) begin : g_nxt
      assign addr_lock_o[e] = cfg_q[e][LOCK_BIT] |
                              (cfg_q[e+1][LOCK_BIT] && mode_of(cfg_q[e+1]) == MODE_TOR);
    end else begin : g_last
      assign addr_lock_o[e] = cfg_q[e][LOCK_BIT];
    end

    // R5
    locked_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_q[e][LOCK_BIT] |=> $stable(cfg_q[e]));
  end

  always_comb begin
    rdata_o = '0;
    for (int e = 0; e < N_ENTRIES; e++)
      if (idx_ok && word_idx == IDX_W'(e / BPW))
        rdata_o[(e % BPW)*8 +: 8] = cfg_q[e];
  end

  assign cfg_q_o = cfg_q;

  // R3 R4
  bad_cfg_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !idx_ok) |=> $stable(cfg_q));
endmodule

// File: rtl/prot_addr_bank.sv
module prot_addr_bank #(
  parameter int XLEN       = 32,
  parameter int N_ENTRIES  = 16,
  parameter int IDX_W      = 5,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [IDX_W-1:0]              idx_i,
  input  logic [XLEN-1:0]               wdata_i,
  input  logic [N_ENTRIES-1:0]          lock_i,
  output logic [XLEN-1:0]               rdata_o,
  output logic [N_ENTRIES-1:0][XLEN-1:0] addr_q_o
);
  localparam int GRAN_BITS = PAGE_SHIFT - 2;
  localparam logic [XLEN-1:0] GRAN_MASK = ~((XLEN'(1) << GRAN_BITS) - XLEN'(1));

  logic [N_ENTRIES-1:0][XLEN-1:0] addr_q;

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        addr_q[e] <= '0;
      else if (we_i && idx_i == IDX_W'(e) && !lock_i[e])
        addr_q[e] <= wdata_i & GRAN_MASK;
    end

    // R6 R7
    frozen_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_i[e] |=> $stable(addr_q[e]));
  end

  always_comb begin
    rdata_o = '0;
    for (int e = 0; e < N_ENTRIES; e++)
      if (idx_i == IDX_W'(e)) rdata_o = addr_q[e];
  end

  assign addr_q_o = addr_q;

  // R8
  addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx_i >= IDX_W'(N_ENTRIES)) |=> $stable(addr_q));
endmodule

// File: rtl/prot_cfg_regfile.sv
module prot_cfg_regfile #(
  parameter int XLEN       = 32,
  parameter int N_ENTRIES  = 16,
  parameter int PAGE_SHIFT = 12,
  parameter int IDX_W      = $clog2(N_ENTRIES) + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic                      re_i,
  input  logic                      sel_addr_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  logic [XLEN-1:0]           wdata_i,
  output logic [XLEN-1:0]           rdata_o,
  output logic [8*N_ENTRIES-1:0]    cfg_table_o,
  output logic [XLEN*N_ENTRIES-1:0] addr_table_o
);
  logic [XLEN-1:0]                cfg_rdata, addr_rdata;
  logic [N_ENTRIES-1:0]           addr_lock;
  logic [N_ENTRIES-1:0][7:0]      cfg_q;
  logic [N_ENTRIES-1:0][XLEN-1:0] addr_q;

  prot_cfg_bank #(.XLEN(XLEN), .N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i && !sel_addr_i),
    .idx_i      (idx_i),
    .wdata_i    (wdata_i),
    .rdata_o    (cfg_rdata),
    .cfg_q_o    (cfg_q),
    .addr_lock_o(addr_lock)
  );

  prot_addr_bank #(.XLEN(XLEN), .N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W),
                   .PAGE_SHIFT(PAGE_SHIFT)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i && sel_addr_i),
    .idx_i   (idx_i),
    .wdata_i (wdata_i),
    .lock_i  (addr_lock),
    .rdata_o (addr_rdata),
    .addr_q_o(addr_q)
  );

  assign rdata_o      = re_i ? (sel_addr_i ? addr_rdata : cfg_rdata) : '0;
  assign cfg_table_o  = cfg_q;
  assign addr_table_o = addr_q;

  // R10
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(cfg_table_o) && $stable(addr_table_o)));
endmodule

// File: tb/tb_prot_cfg_regfile.sv
`timescale 1ns/1ps
module tb_prot_cfg_regfile;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0, re = 1'b0, sel = 1'b0;
  logic [4:0]  idx = '0;
  logic [63:0] wd = '0;
  logic [31:0] rd32;
  logic [63:0] rd64;
  logic [127:0]  cfg32, cfg64;
  logic [511:0]  at32;
  logic [1023:0] at64;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0]  mcfg [2][16];
  logic [63:0] maddr[2][16];

  always #2.5 clk = ~clk;

  prot_cfg_regfile #(.XLEN(32)) dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re), .sel_addr_i(sel),
    .idx_i(idx), .wdata_i(wd[31:0]), .rdata_o(rd32),
    .cfg_table_o(cfg32), .addr_table_o(at32));

  prot_cfg_regfile #(.XLEN(64)) dut64 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re), .sel_addr_i(sel),
    .idx_i(idx), .wdata_i(wd), .rdata_o(rd64),
    .cfg_table_o(cfg64), .addr_table_o(at64));

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] m_read(int k, bit s, int i, bit r);
    logic [63:0] v = '0;
    int bpw = k ? 8 : 4;
    int w;
    if (!r) return '0;
    if (s) return (i < 16) ? maddr[k][i] : '0;
    if (k == 1 && i[0]) return '0;
    w = k ? i / 2 : i;
    if (w * bpw >= 16) return '0;
    for (int b = 0; b < bpw; b++) v[b*8 +: 8] = mcfg[k][w*bpw + b];
    return v;
  endfunction

  task automatic m_write(int k, bit s, int i, logic [63:0] d);
    int bpw = k ? 8 : 4;
    int w;
    bit lk;
    if (!s) begin
      if (k == 1 && i[0]) return;
      w = k ? i / 2 : i;
      for (int b = 0; b < bpw; b++)
        if (w*bpw + b < 16 && !mcfg[k][w*bpw + b][7])
          mcfg[k][w*bpw + b] = d[b*8 +: 8];
    end else if (i < 16) begin
      lk = mcfg[k][i][7];
      if (i < 15 && mcfg[k][i+1][7] && mcfg[k][i+1][4:3] == 2'b01) lk = 1;
      if (!lk) maddr[k][i] = d & 64'hFFFF_FFFF_FFFF_FC00 & (k ? '1 : 64'hFFFF_FFFF);
    end
  endtask

  task automatic chk_tables(string tag);
    for (int e = 0; e < 16; e++) begin
      chk(tag, "cfg32", {56'd0, cfg32[e*8 +: 8]}, {56'd0, mcfg[0][e]});
      chk(tag, "cfg64", {56'd0, cfg64[e*8 +: 8]}, {56'd0, mcfg[1][e]});
      chk(tag, "addr32", {32'd0, at32[e*32 +: 32]}, maddr[0][e]);
      chk(tag, "addr64", at64[e*64 +: 64], maddr[1][e]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; we = 0; re = 0;
    for (int k = 0; k < 2; k++)
      for (int e = 0; e < 16; e++) begin mcfg[k][e] = '0; maddr[k][e] = '0; end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk_tables("R1");
  endtask

  // inputs change just after negedge; reads sampled before posedge, tables after
  task automatic op(bit w, bit r, bit s, int i, logic [63:0] d, string tag, bit full = 0);
    @(negedge clk);
    we = w; re = r; sel = s; idx = 5'(i); wd = d;
    #1;
    chk(tag, "rd32", {32'd0, rd32}, {32'd0, m_read(0, s, i, r) & 64'hFFFF_FFFF});
    chk(tag, "rd64", rd64, m_read(1, s, i, r));
    @(posedge clk);
    if (w) begin
      m_write(0, s, i, {32'd0, d[31:0]});
      m_write(1, s, i, d);
    end
    if (full) begin
      @(negedge clk);
      #1;
      chk_tables(tag);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    op(0, 1, 0, 0, 0, "R1");
    op(0, 1, 1, 3, 0, "R1");
    // R2 packing and readback
    op(1, 0, 0, 0, 64'h8877_6655_4433_2211, "R2", 1);
    op(0, 1, 0, 0, 0, "R2");
    op(1, 1, 0, 2, 64'h0f0e_0d0c_0b0a_0908, "R2", 1);
    op(0, 1, 0, 2, 0, "R2");
    // R3 odd index on 64-bit
    op(1, 1, 0, 1, 64'hdead_beef_cafe_f00d, "R3", 1);
    op(0, 1, 0, 1, 0, "R3");
    op(0, 1, 0, 3, 0, "R3");
    // R4 word past the table
    op(1, 1, 0, 4, 64'h1111_2222_3333_4444, "R4", 1);
    op(1, 1, 0, 6, 64'h5555_6666_7777_8888, "R4", 1);
    op(0, 1, 0, 31, 0, "R4");
    // R9 masking
    op(1, 0, 1, 0, 64'hffff_ffff_ffff_ffff, "R9", 1);
    op(1, 0, 1, 5, 64'h0000_0012_3456_7fff, "R9", 1);
    op(0, 1, 1, 5, 0, "R9");
    // R5 lock byte 1 as locked TOR (0x88), byte 5 as locked NA4 (0x90)
    op(1, 0, 0, 0, 64'h0000_9000_0000_8800, "R5", 1);
    op(1, 0, 0, 1, 64'h0000_9000_0000_0000, "R5", 1);
    op(1, 1, 0, 0, 64'haabb_ccdd_eeff_0011, "R5", 1);
    op(1, 1, 0, 0, 64'h0, "R5", 1);
    op(0, 1, 0, 0, 0, "R5");
    // R6 own lock; R7 locked TOR successor freezes entry 0, locked NA4 does not freeze 4
    op(1, 0, 1, 1, 64'h0000_0000_abcd_e000, "R6", 1);
    op(1, 0, 1, 0, 64'h0000_0000_1234_5000, "R7", 1);
    op(1, 0, 1, 4, 64'h0000_0000_7777_7000, "R7", 1);
    op(0, 1, 1, 4, 0, "R7");
    // R8 address index past the table
    op(1, 1, 1, 16, 64'hffff_ffff_ffff_ffff, "R8", 1);
    op(1, 1, 1, 31, 64'h1234_5678_9abc_def0, "R8", 1);
    // R10 strobe low and we low
    op(0, 0, 1, 5, 0, "R10", 1);
    op(0, 0, 0, 0, 0, "R10", 1);
    // R11 table layout via full compare
    op(0, 1, 1, 0, 0, "R11", 1);

    for (int pass = 0; pass < 2; pass++) begin
      for (int n = 0; n < 3000; n++) begin
        bit s = $urandom_range(0, 1);
        int i = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 31)
              : (s ? $urandom_range(0, 15) : $urandom_range(0, 4));
        logic [63:0] d = {$urandom, $urandom};
        // keep locks sparse so writes keep landing
        if (!s && $urandom_range(0, 3) != 0) d = d & 64'h7f7f_7f7f_7f7f_7f7f;
        op($urandom_range(0, 3) != 0, $urandom_range(0, 4) != 0, s, i, d,
           s ? (i >= 16 ? "R8" : "R7") : "R5", (n % 16) == 0);
      end
      do_reset();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule